// File: doc/BRIEF.md
# Supply Loss Access Guard

This block sits between a host's memory strobes and a battery-backed static RAM. It watches three digitized supply-level flags and decides, every system clock, whether the memory may be accessed. It also decides whether the array runs from the external supply or from the backup cell. While the supply is healthy, the chip selects and read/write strobes pass straight through to the array. When the supply sags, the array is deselected: writes are blocked, the data bus is released, and every host control is ignored. If the supply falls far enough, the block switches the array over to the battery.

When the supply comes back, access stays blocked for a fixed number of clock cycles after the upper flag returns. This gives the system time to settle. A write strobe that is already low at the end of that wait does nothing until it has been seen high once. This stops a stale strobe from landing a write as the array comes back.

The controller has four states:
- NORMAL: access allowed.
- PROTECT: deselected, running from the external supply.
- BATTERY: deselected, running from the battery.
- RECOVER: deselected while the recovery wait counts down.

The transitions are:
- NORMAL→PROTECT: on supply drop.
- PROTECT→BATTERY: below the switch-over level.
- BATTERY→PROTECT: back above the switch-over level.
- PROTECT→RECOVER: upper flag valid again.
- RECOVER→NORMAL: wait elapsed.
- RECOVER→PROTECT: drop during the wait.

Top module: `supply_guard`

## Requirements
- R1: While reset is asserted the block is in PROTECT: `bus_hiz`=1, `mem_we_n`=1, `mem_oe_n`=1, `bat_sel`=0.
- R2: In NORMAL, with the array selected (`cs_a_n`=0 and `cs_b`=1):
  - `mem_oe_n` is 0 when `rd_n`=0 and `wr_n`=1.
  - `mem_we_n` is 0 when `wr_n`=0 and the write is armed.
  - Whenever the array is not selected, both are 1.
  - `bus_hiz`=0 in NORMAL.
- R3: Each supply flag passes two synchronizer flops before the state register. A loss of the upper flag is reflected at the outputs on the third rising clock edge after the input changes: the state goes to PROTECT, `bus_hiz`=1, and both enables are 1.
- R4: In any state other than NORMAL, `cs_a_n`, `cs_b`, `rd_n` and `wr_n` have no effect: `mem_we_n`=`mem_oe_n`=`bus_hiz`=1.
- R5: From PROTECT, when both the switch-over flag and the lower flag are 0, the state goes to BATTERY and `bat_sel`=1. `bat_sel` is 1 only in BATTERY, where `bus_hiz` is also 1.
- R6: In BATTERY, when the switch-over flag or the lower flag returns to 1, the state goes back to PROTECT and `bat_sel` drops to 0 (three edges after the input change).
- R7: From PROTECT, a valid upper flag enters RECOVER. NORMAL is reached exactly `REC_CYC` clock edges after RECOVER is entered, which is 3+`REC_CYC` edges after the flag input rises. NORMAL is reachable only from RECOVER.
- R8: A loss of the upper flag during RECOVER returns the state to PROTECT and clears the recovery count, so a later return needs the full `REC_CYC` edges again.
- R9: On each entry to NORMAL the write is disarmed. `mem_we_n` stays 1 until `wr_n` has been sampled at 1 on a clock edge in NORMAL.
- R10: The upper flag counts as valid only while the lower flag is also 1. The need for the battery counts only while the lower flag is also 0. So upper=1 with lower=0 gives PROTECT, and switch-over=0 with lower=1 does not select the battery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sup_above_hi | input | 1 | supply above upper fail level (asynchronous) |
| sup_above_lo | input | 1 | supply above lower fail level (asynchronous) |
| sup_above_sw | input | 1 | supply above battery switch-over level (asynchronous) |
| cs_a_n | input | 1 | active-low chip select from host |
| cs_b | input | 1 | active-high chip select from host |
| rd_n | input | 1 | raw active-low read strobe |
| wr_n | input | 1 | raw active-low write strobe |
| mem_we_n | output | 1 | gated write enable to the array |
| mem_oe_n | output | 1 | gated output enable to the array |
| bus_hiz | output | 1 | deselect: release the data bus |
| bat_sel | output | 1 | 1 = array and clock powered from battery |

## Verification
The bench builds the block with `REC_CYC` set to 16 rather than the default of 1000. This puts the whole recovery wait within a few dozen cycles, so the exact edge where NORMAL returns can be checked one cycle before and on the edge itself. The short wait also leaves room for an aborted recovery followed by a full restart of the count. Every comparator change is placed relative to the two synchronizer stages, so the third-edge latency of deselection and battery switching is checked on both sides of its edge.

// File: rtl/sg_pkg.sv
package sg_pkg;
    // controller states
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_PROTECT = 2'd1,
        ST_BATTERY = 2'd2,
        ST_RECOVER = 2'd3
    } sg_state_e;

    // supply flag vector layout
    localparam int FLAG_N = 3;
    localparam int IDX_HI = 0;
    localparam int IDX_LO = 1;
    localparam int IDX_SW = 2;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                d_sync[i] <= 1'b0;
            end else begin
                stage1[i] <= d_async[i];
                d_sync[i] <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/sg_rec_timer.sv
module sg_rec_timer #(
    parameter int REC_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (REC_CYC < 2) ? 1 : $clog2(REC_CYC);
    localparam logic [CW-1:0] LAST = CW'(REC_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
    import sg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hi_ok,
    input  logic      bat_need,
    input  logic      rec_done,
    output sg_state_e st
);
    sg_state_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_PROTECT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_NORMAL:  if (!hi_ok) st_nx = ST_PROTECT;
            ST_PROTECT: begin
                if (bat_need)   st_nx = ST_BATTERY;
                else if (hi_ok) st_nx = ST_RECOVER;
            end
            ST_BATTERY: if (!bat_need) st_nx = ST_PROTECT;
            ST_RECOVER: begin
                if (!hi_ok)        st_nx = ST_PROTECT;
                else if (rec_done) st_nx = ST_NORMAL;
            end
            default: st_nx = ST_PROTECT;
        endcase
    end
endmodule

// File: rtl/sg_gate.sv
module sg_gate
    import sg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sg_state_e st,
    input  logic      cs_a_n,
    input  logic      cs_b,
    input  logic      rd_n,
    input  logic      wr_n,
    output logic      we_n,
    output logic      oe_n,
    output logic      hiz,
    output logic      bat
);
    logic armed;
    logic sel;

    assign sel = !cs_a_n && cs_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                armed <= 1'b0;
        else if (st != ST_NORMAL)  armed <= 1'b0;
        else if (wr_n)             armed <= 1'b1;
    end

    always_comb begin
        we_n = 1'b1;
        oe_n = 1'b1;
        hiz  = 1'b1;
        bat  = 1'b0;
        unique case (st)
            ST_NORMAL: begin
                hiz  = 1'b0;
                we_n = !(sel && armed && !wr_n);
                oe_n = !(sel && !rd_n && wr_n);
            end
            ST_PROTECT: ;
            ST_BATTERY: bat = 1'b1;
            ST_RECOVER: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import sg_pkg::*;
#(
    parameter int REC_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_hi,
    input  logic sup_above_lo,
    input  logic sup_above_sw,
    input  logic cs_a_n,
    input  logic cs_b,
    input  logic rd_n,
    input  logic wr_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic bus_hiz,
    output logic bat_sel
);
    logic [FLAG_N-1:0] flg_raw, flg_s;
    logic              hi_ok, bat_need, rec_done;
    sg_state_e         st_q;

    assign flg_raw[IDX_HI] = sup_above_hi;
    assign flg_raw[IDX_LO] = sup_above_lo;
    assign flg_raw[IDX_SW] = sup_above_sw;

    sg_sync #(.W(FLAG_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(flg_raw), .d_sync(flg_s)
    );

    // comparator ordering mask: upper needs lower, battery needs not-lower
    assign hi_ok    = flg_s[IDX_HI] && flg_s[IDX_LO];
    assign bat_need = !flg_s[IDX_SW] && !flg_s[IDX_LO];

    sg_rec_timer #(.REC_CYC(REC_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st_q == ST_RECOVER), .done(rec_done)
    );

    sg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hi_ok(hi_ok), .bat_need(bat_need),
        .rec_done(rec_done), .st(st_q)
    );

    sg_gate u_gate (
        .clk(clk), .rst_n(rst_n), .st(st_q),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .rd_n(rd_n), .wr_n(wr_n),
        .we_n(mem_we_n), .oe_n(mem_oe_n), .hiz(bus_hiz), .bat(bat_sel)
    );
endmodule

// File: rtl/sg_checker.sv
module sg_checker
    import sg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input sg_state_e         st,
    input logic [FLAG_N-1:0] flg_s,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              bus_hiz,
    input logic              bat_sel
);
    logic hi_s, lo_s, sw_s;
    assign hi_s = flg_s[IDX_HI];
    assign lo_s = flg_s[IDX_LO];
    assign sw_s = flg_s[IDX_SW];

    AST_DROP_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_s |=> bus_hiz); // R3
    AST_DESEL_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_NORMAL) |-> (mem_we_n && mem_oe_n)); // R4
    AST_BAT_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROTECT && !sw_s && !lo_s) |=> bat_sel); // R5
    AST_BAT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> bus_hiz); // R5
    AST_BAT_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sel && (sw_s || lo_s)) |=> !bat_sel); // R6
    AST_NORMAL_FROM_REC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_hiz) |-> ($past(st) == ST_RECOVER)); // R7
    AST_REC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECOVER && !(hi_s && lo_s)) |=> (st == ST_PROTECT)); // R8
    AST_ENTRY_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_hiz) |-> mem_we_n); // R9
    AST_UPPER_NEEDS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_s && !lo_s) |=> bus_hiz); // R10
endmodule

bind supply_guard sg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_q), .flg_s(flg_s),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .bus_hiz(bus_hiz), .bat_sel(bat_sel)
);

// File: tb/test_supply_guard.sv
module test_supply_guard;
    localparam int REC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b1, lo = 1'b1, sw = 1'b1;
    logic cs_a_n = 1'b0, cs_b = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic mem_we_n, mem_oe_n, bus_hiz, bat_sel;

    always #10 clk = ~clk; // 50 MHz

    supply_guard #(.REC_CYC(REC)) i_supply_guard (
        .clk(clk), .rst_n(rst_n),
        .sup_above_hi(hi), .sup_above_lo(lo), .sup_above_sw(sw),
        .cs_a_n(cs_a_n), .cs_b(cs_b), .rd_n(rd_n), .wr_n(wr_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .bus_hiz(bus_hiz), .bat_sel(bat_sel)
    );

    typedef struct {
        logic  we_n;
        logic  oe_n;
        logic  hiz;
        logic  bat;
        string req;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // driver side: push what the outputs must be at the next falling edge
    task automatic expect_out(input logic we, input logic oe, input logic hz,
                              input logic bt, input string req);
        exp_t e;
        e.we_n = we; e.oe_n = oe; e.hiz = hz; e.bat = bt; e.req = req;
        q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if ({mem_we_n, mem_oe_n, bus_hiz, bat_sel} !== {e.we_n, e.oe_n, e.hiz, e.bat}) begin
                n_bad++;
                $display("FAIL %s: we/oe/hiz/bat actual %b%b%b%b expected %b%b%b%b",
                         e.req, mem_we_n, mem_oe_n, bus_hiz, bat_sel,
                         e.we_n, e.oe_n, e.hiz, e.bat);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(2);
        expect_out(1, 1, 1, 0, "R1 reset");
        tick(1);
        rst_n = 1'b1;
        tick(40);
        expect_out(1, 1, 0, 0, "R2 idle normal");
        tick(1); rd_n = 1'b0;
        expect_out(1, 0, 0, 0, "R2 read");
        tick(1); rd_n = 1'b1; wr_n = 1'b0;
        expect_out(0, 1, 0, 0, "R2 write");
        tick(1); cs_a_n = 1'b1;
        expect_out(1, 1, 0, 0, "R2 deselect a");
        tick(1); cs_a_n = 1'b0; cs_b = 1'b0;
        expect_out(1, 1, 0, 0, "R2 deselect b");
        tick(1); cs_b = 1'b1;
        expect_out(0, 1, 0, 0, "R2 write again");
        // R3: supply drop during active write
        tick(1); hi = 1'b0;
        tick(2);
        expect_out(0, 1, 0, 0, "R3 before third edge");
        tick(1);
        expect_out(1, 1, 1, 0, "R3 on third edge");
        // R4: strobes ignored while deselected
        tick(1); rd_n = 1'b0; wr_n = 1'b1;
        expect_out(1, 1, 1, 0, "R4 read ignored");
        tick(1); rd_n = 1'b1; wr_n = 1'b0;
        expect_out(1, 1, 1, 0, "R4 write ignored");
        // R10: switch-over low but lower still high: no battery
        tick(1); sw = 1'b0;
        tick(4);
        expect_out(1, 1, 1, 0, "R10 lower masks battery");
        // R5: lower falls too
        tick(1); lo = 1'b0;
        tick(2);
        expect_out(1, 1, 1, 0, "R5 before third edge");
        tick(1);
        expect_out(1, 1, 1, 1, "R5 battery selected");
        // R6: switch-over returns
        tick(1); sw = 1'b1;
        tick(2);
        expect_out(1, 1, 1, 1, "R6 before third edge");
        tick(1);
        expect_out(1, 1, 1, 0, "R6 battery released");
        // R10: upper without lower stays protected
        tick(1); hi = 1'b1;
        tick(3 + REC + 4);
        expect_out(1, 1, 1, 0, "R10 upper needs lower");
        // R7 and R9: full recovery with write strobe held low
        tick(1); lo = 1'b1;
        tick(2 + REC);
        expect_out(1, 1, 1, 0, "R7 one edge early");
        tick(1);
        expect_out(1, 1, 0, 0, "R7 normal on time / R9 disarmed");
        tick(1);
        expect_out(1, 1, 0, 0, "R9 still disarmed");
        tick(1); wr_n = 1'b1;
        expect_out(1, 1, 0, 0, "R9 strobe high");
        tick(1); wr_n = 1'b0;
        expect_out(0, 1, 0, 0, "R9 armed write");
        // R8: abort during recovery, then full restart
        tick(1); wr_n = 1'b1; hi = 1'b0;
        tick(3);
        expect_out(1, 1, 1, 0, "R8 protect");
        tick(1); hi = 1'b1;
        tick(3 + 10);
        tick(0); hi = 1'b0;
        tick(3);
        expect_out(1, 1, 1, 0, "R8 aborted");
        tick(1); hi = 1'b1;
        tick(2 + REC);
        expect_out(1, 1, 1, 0, "R8 count restarted");
        tick(1);
        expect_out(1, 1, 0, 0, "R8 normal after full wait");
        tick(2);
        wait (q.size() == 0);
        tick(1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule